// File: doc/BRIEF.md
# Half-Word Left-to-Left Move Unit

This unit executes the four left-to-left half-word transfer instructions of a 36-bit accumulator machine. Each word is split into an 18-bit left half (bits 35..18) and an 18-bit right half (bits 17..0). The unit takes one decoded instruction with its effective address and merges halves between an accumulator and a memory word. It reads the operand only when the instruction needs one. The result goes either to the accumulator file or back to memory. The unit then reports one of three outcomes: success, a memory fault, or an opcode it does not serve.

Instructions enter on a valid/ready channel. `in_ready` is high only while the unit is idle. A beat is taken on a clock edge where `in_valid` and `in_ready` are both high. All fields are captured on that edge, so the source may change them afterwards. The memory port is a request/acknowledge pair. The unit raises `mem_req` and holds the address, direction and write data stable until the cycle in which the memory answers with `mem_ack`. Read data and the error flag are taken in that same acknowledge cycle. The accumulator file is read combinationally through `ac_idx`/`ac_rdata` and written through `ac_we`/`ac_wdata`.

Top module: `hw_move_unit`

## Requirements
- R1: Load form (opcode octal 500) reads memory once and writes the accumulator with {memory left half, accumulator right half}; it never writes memory.
- R2: Immediate form (octal 501) makes no memory access and writes the accumulator with {zero-extended section, accumulator right half}; done follows two cycles after acceptance.
- R3: In the immediate form the section placed in the left half becomes 1 when the address is local, the offset is at most octal 17, and the section exceeds 1; otherwise the effective-address section is used unchanged.
- R4: Store form (octal 502) issues exactly one read and then one write to the same address, writing {accumulator left half, memory right half}; the accumulator is not written.
- R5: Self form (octal 503) with a nonzero accumulator number copies the whole memory word into the accumulator after one read.
- R6: Self form with accumulator number 0 completes with done, no memory access and no accumulator write.
- R7: The opcode is instruction bits 35..27 and the accumulator number is bits 3..0; the other bits are ignored. Any opcode other than octal 500..503 yields a `bad_op` pulse with `bad_pc` = {section, offset} (section shifted left 18), with no memory access and no accumulator write.
- R8: A read answered with `mem_err` ends the instruction with a `fault` pulse, `fault_write`=0 and `fault_addr` = {section, offset}; there is no accumulator write and no further memory access.
- R9: A failed write in the store form gives `fault` with `fault_write`=1 and the same address; the accumulator is not written.
- R10: Each accepted instruction produces exactly one single-cycle pulse on `done`, `fault` or `bad_op`, never two at once; `in_ready` stays low from acceptance through that pulse, and rises in the cycle after it.
- R11: While `mem_req` is high and not acknowledged, `mem_addr`, `mem_we` and `mem_wdata` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Instruction beat valid |
| in_ready | output | 1 | Unit idle, beat can be taken |
| in_ir | input | 36 | Instruction word |
| in_sect | input | 12 | Effective-address section |
| in_ofs | input | 18 | Effective-address offset |
| in_local | input | 1 | Effective address is local |
| in_pc_sect | input | 12 | Program counter section |
| in_pc_ofs | input | 18 | Program counter offset |
| ac_idx | output | 4 | Accumulator number for read and write |
| ac_rdata | input | 36 | Accumulator read data |
| ac_we | output | 1 | Accumulator write strobe |
| ac_wdata | output | 36 | Accumulator write data |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 36 | Memory word address |
| mem_wdata | output | 36 | Memory write data |
| mem_ack | input | 1 | Request accepted and answered this cycle |
| mem_rdata | input | 36 | Read data, valid with mem_ack |
| mem_err | input | 1 | Access failed, valid with mem_ack |
| done | output | 1 | Successful completion pulse |
| fault | output | 1 | Memory fault pulse |
| fault_write | output | 1 | Faulting access was a write |
| fault_addr | output | 36 | Faulting address |
| bad_op | output | 1 | Unserved opcode pulse |
| bad_pc | output | 36 | Program counter of the unserved opcode |

## Verification
Several properties are checked on every cycle by the assertions:
- the three outcome pulses are mutually exclusive and last one cycle;
- the memory request holds while it is unacknowledged;
- a write request only ever follows an acknowledged read;
- the immediate form and the zero-accumulator self form finish without touching memory;
- a read error leads straight to a read fault.

Other behaviour only the bench's scenarios can show:
- the merged data values;
- the section promotion rule at its boundaries (offsets octal 17 and 20, sections 0, 1 and 5, local versus global);
- the exact number of reads and writes per instruction;
- that memory and the accumulator are unchanged after a fault;
- that ignored instruction bits have no effect.

// File: rtl/hw_move_pkg.sv
package hw_move_pkg;
  localparam logic [8:0] OPC_FIRST = 9'o500;

  typedef enum logic [2:0] {
    OP_LL_LOAD,
    OP_LL_IMM,
    OP_LL_STORE,
    OP_LL_SELF,
    OP_ILLEGAL
  } op_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_EXEC,
    ST_READ,
    ST_WRITE,
    ST_DONE,
    ST_FAULT,
    ST_BAD
  } st_e;
endpackage

// File: rtl/hw_move_decode.sv
module hw_move_decode
  import hw_move_pkg::*;
#(
  parameter int OPC_W  = 9,
  parameter int AC_W   = 4,
  parameter int HALF_W = 18,
  parameter int SECT_W = 12,
  parameter int LOCAL_LIMIT = 15
) (
  input  logic [OPC_W-1:0]  opc,
  input  logic [AC_W-1:0]   acn,
  input  logic [SECT_W-1:0] sect,
  input  logic [HALF_W-1:0] ofs,
  input  logic              is_local,
  output op_e               op,
  output logic              ac_zero,
  output logic [HALF_W-1:0] imm_left
);
  localparam logic [OPC_W-1:0] BASE = OPC_W'(OPC_FIRST);
  localparam logic [HALF_W-1:0] LIM = HALF_W'(LOCAL_LIMIT);

  logic promote;

  always_comb begin
    if      (opc == BASE)               op = OP_LL_LOAD;
    else if (opc == BASE + OPC_W'(1))   op = OP_LL_IMM;
    else if (opc == BASE + OPC_W'(2))   op = OP_LL_STORE;
    else if (opc == BASE + OPC_W'(3))   op = OP_LL_SELF;
    else                                op = OP_ILLEGAL;
  end

  assign ac_zero  = (acn == '0);
  // local accumulator reference in a higher section becomes a global one
  assign promote  = is_local && (ofs <= LIM) && (sect > SECT_W'(1));
  assign imm_left = promote ? HALF_W'(1) : HALF_W'(sect);
endmodule

// File: rtl/hw_move_merge.sv
module hw_move_merge
  import hw_move_pkg::*;
#(
  parameter int HALF_W = 18
) (
  input  op_e                 op,
  input  logic [2*HALF_W-1:0] ac_word,
  input  logic [2*HALF_W-1:0] mem_word,
  input  logic [HALF_W-1:0]   imm_left,
  output logic [2*HALF_W-1:0] result
);
  localparam int WORD_W = 2 * HALF_W;

  always_comb begin
    case (op)
      OP_LL_LOAD:  result = {mem_word[WORD_W-1:HALF_W], ac_word[HALF_W-1:0]};
      OP_LL_IMM:   result = {imm_left, ac_word[HALF_W-1:0]};
      OP_LL_STORE: result = {ac_word[WORD_W-1:HALF_W], mem_word[HALF_W-1:0]};
      OP_LL_SELF:  result = mem_word;
      default:     result = '0;
    endcase
  end
endmodule

// File: rtl/hw_move_unit.sv
module hw_move_unit
  import hw_move_pkg::*;
#(
  parameter int HALF_W = 18,
  parameter int SECT_W = 12,
  parameter int AC_W   = 4,
  parameter int OPC_W  = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  output logic                in_ready,
  input  logic [2*HALF_W-1:0] in_ir,
  input  logic [SECT_W-1:0]   in_sect,
  input  logic [HALF_W-1:0]   in_ofs,
  input  logic                in_local,
  input  logic [SECT_W-1:0]   in_pc_sect,
  input  logic [HALF_W-1:0]   in_pc_ofs,
  output logic [AC_W-1:0]     ac_idx,
  input  logic [2*HALF_W-1:0] ac_rdata,
  output logic                ac_we,
  output logic [2*HALF_W-1:0] ac_wdata,
  output logic                mem_req,
  output logic                mem_we,
  output logic [2*HALF_W-1:0] mem_addr,
  output logic [2*HALF_W-1:0] mem_wdata,
  input  logic                mem_ack,
  input  logic [2*HALF_W-1:0] mem_rdata,
  input  logic                mem_err,
  output logic                done,
  output logic                fault,
  output logic                fault_write,
  output logic [2*HALF_W-1:0] fault_addr,
  output logic                bad_op,
  output logic [2*HALF_W-1:0] bad_pc
);
  localparam int WORD_W = 2 * HALF_W;
  localparam int PAD_W  = WORD_W - HALF_W - SECT_W;

  st_e                st_q;
  logic [OPC_W-1:0]   opc_q;
  logic [AC_W-1:0]    acn_q;
  logic [SECT_W-1:0]  sect_q, pcs_q;
  logic [HALF_W-1:0]  ofs_q, pco_q;
  logic               local_q;
  logic [WORD_W-1:0]  res_q;
  logic               wr_ac_q, fwr_q;

  op_e                op;
  logic               ac_zero;
  logic [HALF_W-1:0]  imm_left;
  logic [WORD_W-1:0]  merged;
  logic [WORD_W-1:0]  ea;

  hw_move_decode #(
    .OPC_W(OPC_W), .AC_W(AC_W), .HALF_W(HALF_W), .SECT_W(SECT_W), .LOCAL_LIMIT(15)
  ) dec_i (
    .opc(opc_q), .acn(acn_q), .sect(sect_q), .ofs(ofs_q), .is_local(local_q),
    .op(op), .ac_zero(ac_zero), .imm_left(imm_left)
  );

  hw_move_merge #(.HALF_W(HALF_W)) mrg_i (
    .op(op), .ac_word(ac_rdata), .mem_word(mem_rdata), .imm_left(imm_left),
    .result(merged)
  );

  assign ea = {{PAD_W{1'b0}}, sect_q, ofs_q};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      opc_q   <= '0;
      acn_q   <= '0;
      sect_q  <= '0;
      ofs_q   <= '0;
      local_q <= 1'b0;
      pcs_q   <= '0;
      pco_q   <= '0;
      res_q   <= '0;
      wr_ac_q <= 1'b0;
      fwr_q   <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: if (in_valid) begin
          opc_q   <= in_ir[WORD_W-1 -: OPC_W];
          acn_q   <= in_ir[AC_W-1:0];
          sect_q  <= in_sect;
          ofs_q   <= in_ofs;
          local_q <= in_local;
          pcs_q   <= in_pc_sect;
          pco_q   <= in_pc_ofs;
          st_q    <= ST_EXEC;
        end
        ST_EXEC: begin
          case (op)
            OP_ILLEGAL: st_q <= ST_BAD;
            OP_LL_IMM: begin
              res_q   <= merged;
              wr_ac_q <= 1'b1;
              st_q    <= ST_DONE;
            end
            OP_LL_SELF: begin
              if (ac_zero) begin
                wr_ac_q <= 1'b0;
                st_q    <= ST_DONE;
              end else begin
                st_q <= ST_READ;
              end
            end
            default: st_q <= ST_READ;
          endcase
        end
        ST_READ: if (mem_ack) begin
          if (mem_err) begin
            fwr_q <= 1'b0;
            st_q  <= ST_FAULT;
          end else begin
            res_q <= merged;
            if (op == OP_LL_STORE) begin
              st_q <= ST_WRITE;
            end else begin
              wr_ac_q <= 1'b1;
              st_q    <= ST_DONE;
            end
          end
        end
        ST_WRITE: if (mem_ack) begin
          if (mem_err) begin
            fwr_q <= 1'b1;
            st_q  <= ST_FAULT;
          end else begin
            wr_ac_q <= 1'b0;
            st_q    <= ST_DONE;
          end
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  assign in_ready    = (st_q == ST_IDLE);
  assign ac_idx      = acn_q;
  assign mem_req     = (st_q == ST_READ) || (st_q == ST_WRITE);
  assign mem_we      = (st_q == ST_WRITE);
  assign mem_addr    = ea;
  assign mem_wdata   = res_q;
  assign ac_we       = (st_q == ST_DONE) && wr_ac_q;
  assign ac_wdata    = res_q;
  assign done        = (st_q == ST_DONE);
  assign fault       = (st_q == ST_FAULT);
  assign fault_write = fwr_q;
  assign fault_addr  = ea;
  assign bad_op      = (st_q == ST_BAD);
  assign bad_pc      = {{PAD_W{1'b0}}, pcs_q, pco_q};

  // R10: outcome pulses never overlap
  a_r10_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({done, fault, bad_op}));

  // R10: done lasts one cycle and the unit is ready right after it
  a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done && in_ready);

  // R11: an unanswered request keeps its address, direction and data
  a_r11_req_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> mem_req && $stable(mem_addr) && $stable(mem_we)
                              && $stable(mem_wdata));

  // R4: a write request only starts after an acknowledged read
  a_r4_write_after_read: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(mem_req && mem_we) |-> $past(mem_req && !mem_we && mem_ack));

  // R2: immediate form completes next cycle without memory traffic
  a_r2_imm_no_mem: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC && op == OP_LL_IMM) |=> done && ac_we && !mem_req);

  // R6: self form with accumulator 0 completes without memory traffic
  a_r6_self_noop: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_EXEC && op == OP_LL_SELF && ac_zero) |=> done && !ac_we && !mem_req);

  // R8: a failed read goes straight to a read fault
  a_r8_read_fault: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_we && mem_ack && mem_err) |=> fault && !fault_write && !mem_req);
endmodule

// File: tb/hw_move_unit_tb_top.sv
`timescale 1ns/1ps
module hw_move_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [35:0] in_ir = '0;
  logic [11:0] in_sect = '0;
  logic [17:0] in_ofs = '0;
  logic        in_local = 1'b0;
  logic [11:0] in_pc_sect = '0;
  logic [17:0] in_pc_ofs = '0;
  logic [3:0]  ac_idx;
  logic [35:0] ac_rdata;
  logic        ac_we;
  logic [35:0] ac_wdata;
  logic        mem_req, mem_we;
  logic [35:0] mem_addr, mem_wdata;
  logic        mem_ack = 1'b0;
  logic [35:0] mem_rdata = '0;
  logic        mem_err = 1'b0;
  logic        done, fault, fault_write, bad_op;
  logic [35:0] fault_addr, bad_pc;

  always #2 clk = ~clk;

  hw_move_unit dut_i (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_ir(in_ir),
    .in_sect(in_sect), .in_ofs(in_ofs), .in_local(in_local),
    .in_pc_sect(in_pc_sect), .in_pc_ofs(in_pc_ofs),
    .ac_idx(ac_idx), .ac_rdata(ac_rdata), .ac_we(ac_we), .ac_wdata(ac_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata), .mem_err(mem_err),
    .done(done), .fault(fault), .fault_write(fault_write), .fault_addr(fault_addr),
    .bad_op(bad_op), .bad_pc(bad_pc)
  );

  int n_chk = 0;
  int n_err = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [35:0] act, input logic [35:0] exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // accumulator file and memory models
  logic [35:0] acf [16];
  logic [35:0] mem [logic [35:0]];
  assign ac_rdata = acf[ac_idx];

  int          lat = 0;
  int          lat_cnt = 0;
  int          rd_cnt = 0;
  int          wr_cnt = 0;
  bit          err_rd_en = 0, err_wr_en = 0;
  logic [35:0] err_rd_addr = '0, err_wr_addr = '0;
  logic [35:0] held_addr, held_wdata;
  logic        held_we;
  bit          holding = 0;

  function automatic logic [35:0] peek(input logic [35:0] a);
    return mem.exists(a) ? mem[a] : 36'h0;
  endfunction

  always @(negedge clk) begin
    if (mem_ack) begin
      mem_ack <= 1'b0;
      mem_err <= 1'b0;
    end else if (rst_n && mem_req) begin
      if (holding) begin
        chk(mem_addr == held_addr && mem_we == held_we && mem_wdata == held_wdata,
            "R11", "request held", mem_addr, held_addr);
      end
      if (lat_cnt >= lat) begin
        lat_cnt = 0;
        holding = 0;
        mem_ack <= 1'b1;
        if (!mem_we) begin
          rd_cnt++;
          if (err_rd_en && mem_addr == err_rd_addr) mem_err <= 1'b1;
          else mem_rdata <= peek(mem_addr);
        end else begin
          wr_cnt++;
          if (err_wr_en && mem_addr == err_wr_addr) mem_err <= 1'b1;
          else mem[mem_addr] = mem_wdata;
        end
      end else begin
        lat_cnt++;
        holding = 1;
        held_addr = mem_addr;
        held_we = mem_we;
        held_wdata = mem_wdata;
      end
    end
  end

  // scoreboard
  typedef struct {
    int          kind;   // 0 done, 1 fault, 2 bad opcode
    bit          acw;
    logic [3:0]  acn;
    logic [35:0] acv;
    bit          fwr;
    logic [35:0] addr;
    int          nrd;
    int          nwr;
    string       req;
  } exp_t;

  exp_t exp_q[$];
  int   n_evt = 0;
  bit   busy = 0;
  bit   prev_evt = 0;

  always @(negedge clk) begin
    if (rst_n) begin
      if (busy && in_ready) chk(0, "R10", "ready while busy", 36'd1, 36'd0);
      if (prev_evt && (done || fault || bad_op))
        chk(0, "R10", "outcome longer than one cycle", 36'd1, 36'd0);
      if (ac_we && !done) chk(0, "R10", "ac write outside done", 36'd1, 36'd0);
      if (!prev_evt && (done || fault || bad_op)) begin
        exp_t e;
        int   k;
        k = done ? 0 : (fault ? 1 : 2);
        if (exp_q.size() == 0) begin
          chk(0, "R10", "unexpected outcome", 36'(k), 36'd9);
        end else begin
          e = exp_q.pop_front();
          chk(k == e.kind && $countones({done, fault, bad_op}) == 1, e.req,
              "outcome kind", 36'(k), 36'(e.kind));
          chk(ac_we == e.acw, e.req, "ac write strobe", 36'(ac_we), 36'(e.acw));
          if (e.acw)
            chk(ac_idx == e.acn && ac_wdata == e.acv, e.req, "ac write data",
                ac_wdata, e.acv);
          if (k == 1)
            chk(fault_write == e.fwr && fault_addr == e.addr, e.req, "fault info",
                {fault_write, fault_addr[34:0]}, {e.fwr, e.addr[34:0]});
          if (k == 2)
            chk(bad_pc == e.addr, e.req, "bad opcode pc", bad_pc, e.addr);
          chk(rd_cnt == e.nrd && wr_cnt == e.nwr, e.req, "memory accesses rd/wr",
              36'(rd_cnt * 16 + wr_cnt), 36'(e.nrd * 16 + e.nwr));
        end
        if (ac_we) acf[ac_idx] = ac_wdata;
        busy = 0;
        n_evt++;
      end
      prev_evt = done || fault || bad_op;
    end
  end

  function automatic logic [35:0] mk(input logic [8:0] opc, input logic [3:0] a,
                                     input logic [22:0] noise);
    return {opc, noise, a};
  endfunction

  // driver: compute the expected outcome, queue it, issue, wait
  task automatic run(input logic [35:0] ir, input logic [11:0] s, input logic [17:0] o,
                     input bit loc, input string req);
    exp_t        e;
    logic [8:0]  opc;
    logic [3:0]  a;
    logic [35:0] addr, av, mv, sec;
    bit          rerr, werr;
    int          tgt;
    opc  = ir[35:27];
    a    = ir[3:0];
    addr = {6'b0, s, o};
    av   = acf[a];
    mv   = peek(addr);
    rerr = err_rd_en && addr == err_rd_addr;
    werr = err_wr_en && addr == err_wr_addr;
    e = '{kind: 0, acw: 0, acn: a, acv: '0, fwr: 0, addr: addr, nrd: 0, nwr: 0, req: req};
    case (opc)
      9'o500: begin
        e.nrd = 1;
        if (rerr) e.kind = 1;
        else begin e.acw = 1; e.acv = {mv[35:18], av[17:0]}; end
      end
      9'o501: begin
        sec = (loc && o <= 18'o17 && s > 12'd1) ? 36'd1 : 36'(s);
        e.acw = 1;
        e.acv = {sec[17:0], av[17:0]};
      end
      9'o502: begin
        e.nrd = 1;
        if (rerr) e.kind = 1;
        else begin
          e.nwr = 1;
          if (werr) begin e.kind = 1; e.fwr = 1; end
        end
      end
      9'o503: begin
        if (a != 0) begin
          e.nrd = 1;
          if (rerr) e.kind = 1;
          else begin e.acw = 1; e.acv = mv; end
        end
      end
      default: begin
        e.kind = 2;
        e.addr = {6'b0, in_pc_sect, in_pc_ofs};
      end
    endcase
    exp_q.push_back(e);
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    rd_cnt = 0;
    wr_cnt = 0;
    in_ir = ir; in_sect = s; in_ofs = o; in_local = loc;
    in_valid = 1'b1;
    tgt = n_evt + 1;
    @(negedge clk);
    in_valid = 1'b0;
    in_ir = '1; in_sect = '1; in_ofs = '1; in_local = 1'b0;
    busy = 1;
    while (n_evt < tgt) @(negedge clk);
    if (opc == 9'o502) begin
      if (e.kind == 0)
        chk(peek(addr) == {av[35:18], mv[17:0]}, req, "stored word",
            peek(addr), {av[35:18], mv[17:0]});
      else
        chk(peek(addr) == mv, req, "memory unchanged after fault", peek(addr), mv);
    end
  endtask

  initial begin
    #400000;
    n_err++;
    $display("FAIL watchdog: actual running expected finished");
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) acf[i] = 36'(i) * 36'h0_1111_1111 + 36'o000005_000003;
    mem[{6'b0, 12'd3, 18'o1000}] = 36'o123456_654321;
    mem[{6'b0, 12'd3, 18'o1001}] = 36'o700001_000077;
    mem[{6'b0, 12'd7, 18'o0}]    = 36'o111111_222222;
    mem[{6'b0, 12'd2, 18'o40}]   = 36'o333333_444444;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R10 reset state
    chk(in_ready && !done && !fault && !bad_op && !mem_req && !ac_we, "R10",
        "reset state", {in_ready, done, fault, bad_op, mem_req, ac_we},
        36'b100000);
    in_pc_sect = 12'd4; in_pc_ofs = 18'o2222;

    lat = 0; run(mk(9'o500, 4'd5, 23'h0), 12'd3, 18'o1000, 0, "R1");
    lat = 2; run(mk(9'o500, 4'd15, 23'h5A5A5), 12'd3, 18'o1001, 0, "R1");
    run(mk(9'o501, 4'd2, 23'h0), 12'd5, 18'o20, 1, "R3");
    run(mk(9'o501, 4'd3, 23'h0), 12'd5, 18'o17, 1, "R3");
    run(mk(9'o501, 4'd4, 23'h0), 12'd5, 18'o3, 0, "R2");
    run(mk(9'o501, 4'd6, 23'h0), 12'd1, 18'o0, 1, "R3");
    run(mk(9'o501, 4'd8, 23'h0), 12'd0, 18'o0, 1, "R3");
    lat = 1; run(mk(9'o502, 4'd7, 23'h0), 12'd7, 18'o0, 0, "R4");
    lat = 3; run(mk(9'o502, 4'd1, 23'h7FFFFF), 12'd2, 18'o40, 0, "R4");
    lat = 0; run(mk(9'o503, 4'd9, 23'h0), 12'd3, 18'o1000, 0, "R5");
    run(mk(9'o503, 4'd0, 23'h0), 12'd3, 18'o1000, 0, "R6");
    run(mk(9'o504, 4'd5, 23'h0), 12'd3, 18'o1000, 0, "R7");
    in_pc_sect = 12'hFFF; in_pc_ofs = 18'o777777;
    run(mk(9'o477, 4'd5, 23'h123), 12'd3, 18'o1000, 0, "R7");
    run(mk(9'o503, 4'd11, 23'h7FFFFF), 12'd7, 18'o0, 0, "R7");
    err_rd_en = 1; err_rd_addr = {6'b0, 12'd3, 18'o1000};
    run(mk(9'o500, 4'd5, 23'h0), 12'd3, 18'o1000, 0, "R8");
    lat = 2; run(mk(9'o503, 4'd12, 23'h0), 12'd3, 18'o1000, 0, "R8");
    run(mk(9'o502, 4'd12, 23'h0), 12'd3, 18'o1000, 0, "R8");
    err_rd_en = 0;
    err_wr_en = 1; err_wr_addr = {6'b0, 12'd3, 18'o1001};
    lat = 1; run(mk(9'o502, 4'd13, 23'h0), 12'd3, 18'o1001, 0, "R9");
    err_wr_en = 0;
    lat = 0; run(mk(9'o500, 4'd13, 23'h0), 12'd3, 18'o1001, 0, "R10");
    run(mk(9'o501, 4'd14, 23'h0), 12'd9, 18'o5, 1, "R10");
    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R10", "outstanding outcomes", 36'(exp_q.size()), 36'd0);
    $display("  Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end
endmodule